// File: doc/BRIEF.md
# Wrapping Return-Address Stack

This block holds the return addresses of a small microcontroller core. When the core takes a subroutine call, or branches to an interrupt handler, it raises a push strobe and presents the return program-counter value. When it leaves a routine, on a plain return, a return that loads a literal, or a return from interrupt, it raises a pop strobe. The entry on top of the stack is always visible on a combinational output, so the next-PC logic can load it in the same cycle as the pop.

The stack has eight entries of thirteen bits each. It lies outside program and data memory, and its pointer cannot be read or written from software. It is a circular buffer with no overflow or underflow detection. After eight pushes, each further push silently replaces the oldest entry. Pops beyond the number of pushes wrap the pointer and return stale entries. The strobes carry no handshake: the stack accepts every push and every pop in the cycle it is raised, so it never applies back-pressure to the core. Deciding which instructions push or pop is the core's job, and so is holding the PC.

Top module: `ret_addr_ring`

## Requirements
- R1: A synchronous active-low reset sets the stack pointer to slot zero. Reset does not clear the stored entries, and their values after reset are unspecified.
- R2: One cycle after a push, `tos` shows the pushed address.
- R3: In the cycle a pop is raised, `tos` already shows the entry being popped. From the next cycle on, `tos` shows the entry below it.
- R4: Up to eight pushes followed by the same number of pops return the addresses in last-in, first-out order.
- R5: The ninth push overwrites the entry written by the first push, and the tenth overwrites the second. After ten pushes, eight pops return pushes ten down to three, and a further pop returns push ten again.
- R6: A pop with no matching push moves the pointer back modulo eight. It has no other effect, and `tos` then shows whatever entry that slot holds.
- R7: When push and pop are raised in the same cycle, the push takes effect and the pop is ignored. The pointer advances by one and `tos` shows the pushed address.
- R8: In a cycle with neither strobe raised, `tos` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push | input | 1 | Push strobe; accepted in the cycle it is high |
| push_addr | input | 13 | Return address to store on a push |
| pop | input | 1 | Pop strobe; accepted in the cycle it is high |
| tos | output | 13 | Entry at the top of the stack, combinational from state |

## Verification
The hardest case to reach from the ports is the point where the pointer wraps through slot zero in both directions. Reaching it takes a run of more than eight pushes, followed by a run of pops long enough to go past the oldest surviving entry. The stimulus reaches this case with long push bursts, pop bursts that run past the number of pushes, and same-cycle push and pop pulses, all issued after a reset in the middle of the run. A behavioural model, built from an array and a modulo counter, marks every slot unknown at reset and compares `tos` only for slots it has written since then.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    RAS_IDLE = 2'd0,
    RAS_PUSH = 2'd1,
    RAS_POP  = 2'd2
  } ras_op_e;

  // push outranks pop when both strobes arrive together
  function automatic ras_op_e ras_decode(input logic push_i, input logic pop_i);
    if (push_i)     return RAS_PUSH;
    else if (pop_i) return RAS_POP;
    else            return RAS_IDLE;
  endfunction

endpackage

// File: rtl/ras_ptr.sv
module ras_ptr #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ras_pkg::ras_op_e op,
  output logic [PW-1:0]   wr_idx,
  output logic [PW-1:0]   top_idx
);
  import ras_pkg::*;

  logic [PW-1:0] ptr_q;
  logic          rst_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      case (op)
        RAS_PUSH: ptr_q <= ptr_q + 1'b1;
        RAS_POP:  ptr_q <= ptr_q - 1'b1;
        default:  ptr_q <= ptr_q;
      endcase
    end
  end

  // one-cycle delayed copy of reset, used to spot the first active cycle
  always_ff @(posedge clk) rst_seen_q <= rst_n;

  assign wr_idx  = ptr_q;
  assign top_idx = ptr_q - 1'b1;

  AST_RESET_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_seen_q == 1'b0) |-> (ptr_q == '0)); // R1

  AST_POP_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RAS_POP) |=> (ptr_q == $past(ptr_q) - 1'b1)); // R6

  AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RAS_PUSH) |=> (ptr_q == $past(ptr_q) + 1'b1)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RAS_IDLE) |=> $stable(ptr_q)); // R8

endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 13,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] widx,
  input  logic [AW-1:0] wdata,
  input  logic [PW-1:0] ridx,
  output logic [AW-1:0] rdata
);

  logic [AW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (widx == PW'(g))) slot_q[g] <= wdata;
    end
  end

  assign rdata = slot_q[ridx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (slot_q[$past(widx)] == $past(wdata))); // R2

endmodule

// File: rtl/ret_addr_ring.sv
module ret_addr_ring #(
  parameter int DEPTH = 8,
  parameter int AW    = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic [AW-1:0] tos
);
  import ras_pkg::*;

  localparam int PW = $clog2(DEPTH);

  ras_op_e       op;
  logic [PW-1:0] wr_idx;
  logic [PW-1:0] top_idx;

  assign op = ras_decode(push, pop);

  ras_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .wr_idx  (wr_idx),
    .top_idx (top_idx)
  );

  ras_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (op == RAS_PUSH),
    .widx  (wr_idx),
    .wdata (push_addr),
    .ridx  (top_idx),
    .rdata (tos)
  );

  AST_PUSH_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (tos == $past(push_addr))); // R2

  AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (tos == $past(push_addr))); // R7

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(tos)); // R8

endmodule

// File: tb/ret_addr_ring_bench.sv
module ret_addr_ring_bench;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push = 1'b0;
  logic          pop = 1'b0;
  logic [AW-1:0] push_addr = '0;
  logic [AW-1:0] tos;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural model
  int m_val [8];
  bit m_known [8];
  int m_p = 0;

  always #5 clk = ~clk;

  ret_addr_ring u_ret_addr_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(push_addr),
    .pop(pop), .tos(tos)
  );

  task automatic model_reset();
    m_p = 0;
    for (int i = 0; i < 8; i++) m_known[i] = 0;
  endtask

  // compare tos with model top, only when the slot is known
  task automatic check(input string tag);
    int t;
    t = (m_p + 7) % 8;
    if (m_known[t]) begin
      compared++;
      if (int'(tos) != m_val[t]) begin
        mismatched++;
        $display("FAIL %s: tos=%0h expected=%0h", tag, tos, m_val[t]);
      end
    end
  endtask

  task automatic cyc(input bit pu, input bit po, input int a, input string tag);
    @(negedge clk);
    push = pu; pop = po; push_addr = AW'(a);
    #1;
    check(tag);
    @(posedge clk);
    if (pu) begin
      m_val[m_p] = a & 13'h1fff;
      m_known[m_p] = 1;
      m_p = (m_p + 1) % 8;
    end else if (po) begin
      m_p = (m_p + 7) % 8;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; push = 0; pop = 0;
    @(posedge clk);
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();

    // R1: after reset the first push lands and reads back
    cyc(1, 0, 13'h0aa, "R1");
    cyc(0, 0, 0, "R1");
    // R2: several patterns
    cyc(1, 0, 13'h1fff, "R2");
    cyc(1, 0, 13'h0000, "R2");
    cyc(1, 0, 13'h1555, "R2");
    cyc(0, 0, 0, "R2");
    // R3: pops expose top in the same cycle
    cyc(0, 1, 0, "R3");
    cyc(0, 1, 0, "R3");
    cyc(0, 1, 0, "R3");
    cyc(0, 0, 0, "R3");

    // R4: eight deep LIFO
    do_reset();
    for (int i = 0; i < 8; i++) cyc(1, 0, 13'h100 + i, "R4");
    for (int i = 0; i < 8; i++) cyc(0, 1, 0, "R4");
    cyc(0, 0, 0, "R4");

    // R5: ten pushes overwrite the oldest two, pops wrap
    do_reset();
    for (int i = 0; i < 10; i++) cyc(1, 0, 13'h0a00 + i, "R5");
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, "R5");
    cyc(0, 0, 0, "R5");

    // R6: pops past the pushes wrap to stale slots
    do_reset();
    for (int i = 0; i < 8; i++) cyc(1, 0, 13'h0300 + 3 * i, "R6");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R6");
    cyc(1, 0, 13'h0777, "R6");
    for (int i = 0; i < 12; i++) cyc(0, 1, 0, "R6");
    cyc(0, 0, 0, "R6");

    // R7: simultaneous strobes, push wins
    cyc(1, 1, 13'h0bad, "R7");
    cyc(1, 1, 13'h0bee, "R7");
    cyc(0, 1, 0, "R7");
    cyc(0, 1, 0, "R7");
    cyc(0, 0, 0, "R7");

    // R8: idle holds tos
    cyc(1, 0, 13'h1234, "R8");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, "R8");

    // R1: reset in the middle of a run, then restart
    cyc(1, 0, 13'h0042, "R1");
    do_reset();
    cyc(1, 0, 13'h0c0c, "R1");
    cyc(1, 1, 13'h0d0d, "R1");
    cyc(0, 1, 0, "R1");
    cyc(0, 1, 0, "R1");
    cyc(0, 0, 0, "R1");

    // mixed traffic
    for (int i = 0; i < 200; i++)
      cyc((i % 3) != 2, (i % 5) == 0 || (i % 3) == 2, (i * 37) & 13'h1fff, "R4");
    cyc(0, 0, 0, "R8");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule